// File: doc/BRIEF.md
# Multiplexed Seven-Segment State Display

This block drives a four-digit, common-anode seven-segment display that time-shares one set of cathode lines. It shows the 11-bit one-hot state of a combination-lock controller in two forms. Three digits show the raw state code as a hexadecimal number: the state is zero-extended to 12 bits and split into nibbles. The fourth digit shows the position of the single set bit as a state index. The logic is purely combinational.

The digit being lit is chosen by two bits tapped from a free-running clock divider outside the block. These are bits 19 and 18 of that divider, and the scan visits digits 0 to 3 in order. The index digit is blanked when the state vector is not a legal one-hot code, so an illegal state is easy to see. The raw hex digits stay visible in that case.

Top module: `seg_state_display`

## Requirements
- R1: The lit digit is the one whose number equals `scan_tap`, the two divider bits 19..18. As the divider counts, digits 0, 1, 2 and 3 are visited in that order.
- R2: Anode enables are active low. Exactly one bit of `an_n` is 0, and bit n is 0 only when `scan_tap` equals n.
- R3: `seg_n` carries the pattern of the lit digit, active low, with segment a in bit 6 down to segment g in bit 0. A digit that shows a hex value always lights at least one segment.
- R4: Hex values map to these patterns: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100, A=0001000, b=1100000, C=0110001, d=1000010, E=0110000, F=0111000.
- R5: Digit 1 shows state bits 3..0, digit 2 shows bits 7..4, and digit 3 shows bits 10..8 with a zero above them. For example, a state of 0x200 reads 2,0,0 on digits 3,2,1.
- R6: For a legal one-hot state with bit n set, digit 0 shows the hex value n. The values run from 0 (INITIAL, bit 0) to A (BAD, bit 10).
- R7: For a state vector with no bits set or with more than one bit set, digit 0 shows the blank pattern 1111111. Digits 1 to 3 still show the raw code.
- R8: `rst` has no effect on the outputs. Asserting it changes neither the anodes nor the cathodes for the same state and tap.
- R9: A change of `state_vec` appears on `seg_n` in the same scan slot, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Reset of the surrounding design; does not affect the outputs |
| state_vec | input | 11 | One-hot state of the lock controller |
| scan_tap | input | 2 | Divider bits 19..18 that select the lit digit |
| an_n | output | 4 | Active-low anode enable per digit |
| seg_n | output | 7 | Active-low cathodes, segment a in bit 6 through g in bit 0 |

## Verification
The assertions assume that `state_vec` and `scan_tap` are driven to known values whenever reset is low. They also assume these inputs change only between evaluation points, so the combinational outputs have settled when they are checked. The stimulus changes both inputs on the falling clock edge and compares on the rising edge. It first holds reset high while the inputs are set, then drops it. It drives every legal one-hot state on every scan position, and illegal vectors with zero, two and many bits set. It also drives nibble values that reach all sixteen hex codes.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int SEG_W = 7;
  localparam int NIB_W = 4;
  localparam logic [SEG_W-1:0] SEG_BLANK = 7'b1111111;

  // active-low pattern, segment a in bit 6 .. g in bit 0
  function automatic logic [SEG_W-1:0] hex_to_seg(input logic [NIB_W-1:0] v);
    logic [SEG_W-1:0] p;
    case (v)
      4'h0: p = 7'b0000001;
      4'h1: p = 7'b1001111;
      4'h2: p = 7'b0010010;
      4'h3: p = 7'b0000110;
      4'h4: p = 7'b1001100;
      4'h5: p = 7'b0100100;
      4'h6: p = 7'b0100000;
      4'h7: p = 7'b0001111;
      4'h8: p = 7'b0000000;
      4'h9: p = 7'b0000100;
      4'hA: p = 7'b0001000;
      4'hB: p = 7'b1100000;
      4'hC: p = 7'b0110001;
      4'hD: p = 7'b1000010;
      4'hE: p = 7'b0110000;
      default: p = 7'b0111000;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/state_index_enc.sv
module state_index_enc #(
  parameter int STATE_W = 11,
  parameter int IDX_W   = $clog2(STATE_W)
) (
  input  logic [STATE_W-1:0] state_vec,
  output logic [IDX_W-1:0]   idx,
  output logic               idx_valid
);
  logic [STATE_W-1:0][IDX_W-1:0] terms;

  // each set bit contributes its own position; OR of all terms
  for (genvar i = 0; i < STATE_W; i++) begin : g_term
    assign terms[i] = state_vec[i] ? IDX_W'(i) : '0;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < STATE_W; i++) idx = idx | terms[i];
  end

  assign idx_valid = $onehot(state_vec);
endmodule

// File: rtl/hex_seg_dec.sv
module hex_seg_dec
  import segdisp_pkg::*;
(
  input  logic [NIB_W-1:0] nib,
  output logic [SEG_W-1:0] seg
);
  assign seg = hex_to_seg(nib);
endmodule

// File: rtl/digit_scan_mux.sv
module digit_scan_mux
  import segdisp_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int DIGITS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]             sel,
  input  logic [DIGITS-1:0][SEG_W-1:0] pats,
  output logic [DIGITS-1:0]            an_n,
  output logic [SEG_W-1:0]             seg_n
);
  always_comb begin
    for (int n = 0; n < DIGITS; n++) an_n[n] = (sel != SEL_W'(n));
    seg_n = pats[sel];
  end
endmodule

// File: rtl/seg_state_display.sv
module seg_state_display
  import segdisp_pkg::*;
#(
  parameter int STATE_W = 11,
  parameter int SEL_W   = 2
) (
  input  logic                   rst,
  input  logic [STATE_W-1:0]     state_vec,
  input  logic [SEL_W-1:0]       scan_tap,
  output logic [(1<<SEL_W)-1:0]  an_n,
  output logic [SEG_W-1:0]       seg_n
);
  localparam int DIGITS     = 1 << SEL_W;
  localparam int HEX_DIGITS = DIGITS - 1;
  localparam int PAD_W      = NIB_W * HEX_DIGITS;
  localparam int IDX_W      = $clog2(STATE_W);

  logic [PAD_W-1:0]             padded;
  logic [DIGITS-1:0][SEG_W-1:0] digit_pat;
  logic [IDX_W-1:0]             idx;
  logic                         idx_valid;
  logic [SEG_W-1:0]             idx_seg;

  assign padded = PAD_W'(state_vec);

  // raw code: digit k+1 shows nibble k
  for (genvar k = 0; k < HEX_DIGITS; k++) begin : g_hex
    hex_seg_dec u_hex (.nib(padded[NIB_W*k +: NIB_W]), .seg(digit_pat[k+1]));
  end

  state_index_enc #(.STATE_W(STATE_W), .IDX_W(IDX_W)) u_enc (
    .state_vec(state_vec), .idx(idx), .idx_valid(idx_valid)
  );

  hex_seg_dec u_idx (.nib(NIB_W'(idx)), .seg(idx_seg));
  assign digit_pat[0] = idx_valid ? idx_seg : SEG_BLANK;

  digit_scan_mux #(.SEL_W(SEL_W), .DIGITS(DIGITS)) u_mux (
    .sel(scan_tap), .pats(digit_pat), .an_n(an_n), .seg_n(seg_n)
  );

  always_comb begin
    if (!rst) begin
      // R2
      anode_onehot_chk: assert ($onehot(~an_n));
      // R1
      anode_match_chk: assert (an_n[scan_tap] == 1'b0);
      // R7
      blank_index_chk: assert ($onehot(state_vec) || an_n[0] || seg_n == SEG_BLANK);
      // R6
      index_hit_chk: assert (!idx_valid || (int'(idx) < STATE_W && state_vec[idx]));
      // R3
      hex_lit_chk: assert (an_n[1] || seg_n != SEG_BLANK);
    end
  end
endmodule

// File: tb/sim_seg_state_display.sv
module sim_seg_state_display;
  typedef struct packed {
    logic [3:0]  an;
    logic [6:0]  seg;
    int unsigned req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] state = 11'h001;
  logic [1:0]  tap = 2'd0;
  logic [3:0]  an_n;
  logic [6:0]  seg_n;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  item_t sb_q[$];

  // hex shapes, bit 6 = segment a, 0 = lit (R4)
  localparam logic [6:0] PAT [16] = '{
    7'h01, 7'h4F, 7'h12, 7'h06, 7'h4C, 7'h24, 7'h20, 7'h0F,
    7'h00, 7'h04, 7'h08, 7'h60, 7'h31, 7'h42, 7'h30, 7'h38};

  always #4 clk = ~clk;

  seg_state_display u0 (.rst(rst), .state_vec(state), .scan_tap(tap),
                        .an_n(an_n), .seg_n(seg_n));

  function automatic logic [6:0] model_digit(logic [10:0] s, int d);
    logic [11:0] wide;
    int hits;
    int pos;
    hits = 0;
    pos = 0;
    wide = {1'b0, s};
    if (d == 0) begin
      for (int i = 0; i < 11; i++) if (s[i]) begin hits++; pos = i; end
      if (hits != 1) return 7'h7F;
      return PAT[pos];
    end
    return PAT[wide[4*(d-1) +: 4]];
  endfunction

  task automatic drive(logic r, logic [10:0] s, logic [1:0] t, int unsigned req);
    item_t it;
    @(negedge clk);
    rst = r;
    state = s;
    tap = t;
    it.an = ~(4'b0001 << t);
    it.seg = model_digit(s, int'(t));
    it.req = req;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      compared++;
      if (an_n !== it.an || seg_n !== it.seg) begin
        mismatched++;
        $display("FAIL R%0d: an_n=%b seg_n=%b expected an_n=%b seg_n=%b",
                 it.req, an_n, seg_n, it.an, it.seg);
      end
    end
  end

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    // R8: outputs with reset held high
    drive(1'b1, 11'h001, 2'd0, 8);
    // R1 R2: full scan sweep
    for (int d = 0; d < 4; d++) drive(1'b0, 11'h040, 2'(d), 1);
    for (int d = 3; d >= 0; d--) drive(1'b0, 11'h008, 2'(d), 2);
    // R3: lit digit pattern routed for each position
    for (int d = 0; d < 4; d++) drive(1'b0, 11'h400, 2'(d), 3);
    // R5 R6: every legal state on every digit
    for (int i = 0; i < 11; i++)
      for (int d = 0; d < 4; d++)
        drive(1'b0, 11'(1 << i), 2'(d), (d == 0) ? 6 : 5);
    // R7: illegal vectors blank the index digit only
    for (int d = 0; d < 4; d++) begin
      drive(1'b0, 11'h000, 2'(d), 7);
      drive(1'b0, 11'h003, 2'(d), 7);
      drive(1'b0, 11'h7FF, 2'(d), 7);
      drive(1'b0, 11'h500, 2'(d), 7);
    end
    // R4: all sixteen hex values on digits 1 and 2
    for (int v = 0; v < 16; v++) begin
      drive(1'b0, {3'b000, 4'(v), 4'(v)}, 2'd1, 4);
      drive(1'b0, {3'b000, 4'(v), 4'(v)}, 2'd2, 4);
    end
    // R8: reset raised mid-run changes nothing
    for (int d = 0; d < 4; d++) drive(1'b1, 11'h200, 2'(d), 8);
    // R9: state change shows in the same slot
    drive(1'b0, 11'h008, 2'd0, 9);
    drive(1'b0, 11'h200, 2'd0, 9);
    drive(1'b0, 11'h200, 2'd3, 9);
    drive(1'b0, 11'h100, 2'd3, 9);
    while (sb_q.size() != 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end
endmodule